// File: doc/BRIEF.md
# Edge-Interrupt General Purpose Port

This block is an eight-line general purpose port. Each line can be a driven output or a high-impedance input, and it can raise a one-clock interrupt event on a chosen transition. Three byte-wide registers set its behaviour: a data register, a direction register and an edge-select register. A simple synchronous register bus reaches them. The events go out as a per-line pulse vector to an interrupt controller outside the block, which owns prioritisation. Pad tri-stating is modelled as an output value vector plus an output-enable vector.

Input pins pass through a two-stage synchronizer. Edge detection works on the synchronized level. For each line the detector forms the equality of the edge-select bit and the synchronized pin, so the "match" signal is edge-select XNOR pin. An event fires when that match signal goes from 0 to 1. As a result, rewriting the edge-select register alone can produce an event on a line whose pin has not moved.

The bus side is a three-state access sequencer:

| State | Meaning |
|---|---|
| ACC_IDLE | No access in the previous cycle. |
| ACC_READ | Read data is being presented. |
| ACC_WRITE | A write was taken in the previous cycle. |

Transitions between states:

| From | To | Condition |
|---|---|---|
| Any state | ACC_READ | A request with write low. |
| Any state | ACC_WRITE | A request with write high. |
| Any state | ACC_IDLE | No request. |

Top module: `gpp_port`

## Requirements
- R1: After reset, all three registers read 0, `pad_oe` is 0 (every line is an input) and no event is raised while pins stay low.
- R2: Direction bit 1 sets `pad_oe` for that line and `pad_o` carries the data register bit. Direction bit 0 leaves the line undriven (`pad_oe` 0), whatever the data register holds.
- R3: A read of the data register returns the stored bit on output lines and the synchronized pin on input lines. A pin change is visible to a read issued two or more clocks later.
- R4: Edge bit 1 selects a rising pin transition and edge bit 0 selects a falling one. The event pulse appears in the third cycle after the pin changes, on each line involved.
- R5: Each event is exactly one clock wide, even while the pin holds its new level. The opposite transition raises no event.
- R6: A write to the edge register raises an event on a line, in the cycle after the write, when it makes edge-bit XNOR pin go from 0 to 1 (pin low with edge 1→0, or pin high with edge 0→1). The opposite rewrite raises none.
- R7: The edge and direction registers read back the last value written. Reads of any other unmapped address return 0, and writes to them change no register.
- R8: A read request is answered with `bus_rvalid` high for exactly one cycle, in the cycle after the request, with `bus_rdata` valid in that cycle. Writes and idle cycles leave `bus_rvalid` low.
- R9: Register offsets are 0x01 for data, 0x03 for edge select and 0x05 for direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read response strobe |
| pad_i | input | 8 | Pin levels seen by the input buffers |
| pad_o | output | 8 | Output value per line |
| pad_oe | output | 8 | Output enable per line |
| irq_evt | output | 8 | One-clock interrupt event per line |

## Verification
The hardest case to reach is an event raised with no pin activity at all. It needs a line whose pin is already settled at a known level, with the edge bit set so the match signal is low, and then a single register write that flips the match signal. The stimulus parks a pin low under a rising selection and then selects falling. It also drives a pin high under a falling selection and then selects rising. The bench checks that the pulse lands in the cycle after the write. The reverse rewrites are checked to give nothing.

// File: rtl/gpp_pkg.sv
package gpp_pkg;

    localparam int unsigned OFS_W = 5;

    localparam logic [OFS_W-1:0] OFS_DATA = 5'h01;
    localparam logic [OFS_W-1:0] OFS_EDGE = 5'h03;
    localparam logic [OFS_W-1:0] OFS_DIR  = 5'h05;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_state_t;

endpackage

// File: rtl/gpp_sync.sv
module gpp_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpp_edge.sv
module gpp_edge #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] edge_sel,
    output logic [WIDTH-1:0] evt
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_line
            logic match;
            logic match_prev_q;
            logic evt_q;

            // match is high when the line sits at the level its edge selects
            assign match = ~(level[g] ^ edge_sel[g]);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    match_prev_q <= 1'b1;
                    evt_q        <= 1'b0;
                end else begin
                    match_prev_q <= match;
                    evt_q        <= match & ~match_prev_q;
                end
            end

            assign evt[g] = evt_q;
        end
    endgenerate

endmodule

// File: rtl/gpp_regs.sv
module gpp_regs
    import gpp_pkg::*;
#(
    parameter int unsigned LINES  = 8,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic [LINES-1:0]  pin_sync,
    output logic [LINES-1:0]  data_reg,
    output logic [LINES-1:0]  edge_reg,
    output logic [LINES-1:0]  dir_reg
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(OFS_EDGE);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);

    acc_state_t state_q, state_d;

    logic [LINES-1:0] data_q, edge_q, dir_q;
    logic [LINES-1:0] rd_mux;
    logic [LINES-1:0] rdata_q;
    logic             wr_fire, rd_fire;

    assign wr_fire = bus_req &  bus_we;
    assign rd_fire = bus_req & ~bus_we;

    // next-state decision
    always_comb begin
        state_d = ACC_IDLE;
        unique case (state_q)
            ACC_IDLE, ACC_READ, ACC_WRITE: begin
                if (rd_fire)      state_d = ACC_READ;
                else if (wr_fire) state_d = ACC_WRITE;
                else              state_d = ACC_IDLE;
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    // outputs of the sequencer
    always_comb begin
        bus_rvalid = 1'b0;
        unique case (state_q)
            ACC_IDLE:  bus_rvalid = 1'b0;
            ACC_READ:  bus_rvalid = 1'b1;
            ACC_WRITE: bus_rvalid = 1'b0;
            default:   bus_rvalid = 1'b0;
        endcase
    end

    // read selection: output lines show the stored bit, inputs show the pin
    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_DATA)      rd_mux = (data_q & dir_q) | (pin_sync & ~dir_q);
        else if (bus_addr == A_EDGE) rd_mux = edge_q;
        else if (bus_addr == A_DIR)  rd_mux = dir_q;
    end

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            edge_q  <= '0;
            dir_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_fire) begin
                if (bus_addr == A_DATA) data_q <= bus_wdata;
                if (bus_addr == A_EDGE) edge_q <= bus_wdata;
                if (bus_addr == A_DIR)  dir_q  <= bus_wdata;
            end
            if (rd_fire) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;
    assign data_reg  = data_q;
    assign edge_reg  = edge_q;
    assign dir_reg   = dir_q;

endmodule

// File: rtl/gpp_port.sv
module gpp_port #(
    parameter int unsigned LINES       = 8,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic [LINES-1:0]  pad_i,
    output logic [LINES-1:0]  pad_o,
    output logic [LINES-1:0]  pad_oe,
    output logic [LINES-1:0]  irq_evt
);

    logic [LINES-1:0] pin_sync;
    logic [LINES-1:0] data_reg, edge_reg, dir_reg;

    gpp_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_i),
        .sync_out (pin_sync)
    );

    gpp_regs #(
        .LINES  (LINES),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pin_sync   (pin_sync),
        .data_reg   (data_reg),
        .edge_reg   (edge_reg),
        .dir_reg    (dir_reg)
    );

    gpp_edge #(
        .WIDTH (LINES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (pin_sync),
        .edge_sel (edge_reg),
        .evt      (irq_evt)
    );

    assign pad_o  = data_reg;
    assign pad_oe = dir_reg;

endmodule

// File: rtl/gpp_port_chk.sv
module gpp_port_chk #(
    parameter int unsigned LINES  = 8,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rvalid,
    input logic [LINES-1:0]  pad_oe,
    input logic [LINES-1:0]  irq_evt
);

    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(gpp_pkg::OFS_DIR);

    // R1: straight out of reset every line is an input and quiet
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_oe == '0 && irq_evt == '0));

    // R5: no line pulses in two consecutive cycles
    assert_evt_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_evt & $past(irq_evt)) == '0));

    // R8: a read request gets a response next cycle
    assert_read_answered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    // R8: no response without a read request the cycle before
    assert_rvalid_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_we));

    // R2: output enables move only after a direction write
    assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_we && bus_addr == A_DIR) |=> $stable(pad_oe));

endmodule

bind gpp_port gpp_port_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .pad_oe     (pad_oe),
    .irq_evt    (irq_evt)
);

// File: tb/gpp_port_bench.sv
module gpp_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_req = 1'b0;
    logic       bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;
    logic [7:0] pad_i = '0;
    logic [7:0] pad_o;
    logic [7:0] pad_oe;
    logic [7:0] irq_evt;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    localparam logic [4:0] A_DATA = 5'h01;
    localparam logic [4:0] A_EDGE = 5'h03;
    localparam logic [4:0] A_DIR  = 5'h05;

    always #5 clk = ~clk;

    gpp_port u_gpp_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pad_i      (pad_i),
        .pad_o      (pad_o),
        .pad_oe     (pad_oe),
        .irq_evt    (irq_evt)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        pad_i = '0;
        bus_req = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_req = 0;
        d = bus_rdata;
        v = bus_rvalid;
    endtask

    // watch six cycles; the pulse must be at cycle lat (0 = none)
    task automatic expect_pulse(input logic [7:0] exp, input int lat, input string req);
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            if (c == lat) check(irq_evt == exp, req, irq_evt, exp);
            else          check(irq_evt == 8'h00, req, irq_evt, 8'h00);
        end
    endtask

    task automatic t_reset();
        logic [7:0] d; logic v;
        apply_reset();
        check(pad_oe == 8'h00, "R1 oe", pad_oe, 8'h00);
        check(irq_evt == 8'h00, "R1 evt", irq_evt, 8'h00);
        bus_read(A_DATA, d, v); check(d == 8'h00, "R1 data", d, 8'h00);
        bus_read(A_EDGE, d, v); check(d == 8'h00, "R1 edge", d, 8'h00);
        bus_read(A_DIR,  d, v); check(d == 8'h00, "R1 dir", d, 8'h00);
    endtask

    task automatic t_direction();
        logic [7:0] d; logic v;
        apply_reset();
        bus_write(A_DATA, 8'hA5);
        check(pad_oe == 8'h00, "R2 undriven", pad_oe, 8'h00);
        bus_write(A_DIR, 8'h0F);
        check(pad_oe == 8'h0F, "R2 oe", pad_oe, 8'h0F);
        check((pad_o & pad_oe) == 8'h05, "R2 out", pad_o & pad_oe, 8'h05);
        pad_i = 8'hF0;
        repeat (2) @(negedge clk);
        bus_read(A_DATA, d, v);
        check(d == 8'hF5, "R3 mixed read", d, 8'hF5);
        pad_i = 8'h3C;
        repeat (2) @(negedge clk);
        bus_read(A_DATA, d, v);
        check(d == 8'h35, "R3 pin follow", d, 8'h35);
    endtask

    task automatic t_edges();
        apply_reset();
        bus_write(A_EDGE, 8'hF1);        // pins low, edge 0->1: no event
        expect_pulse(8'h00, 0, "R6 no event on 0->1 with pin low");
        pad_i = 8'h01;
        expect_pulse(8'h01, 3, "R4 rising line0");
        pad_i = 8'h00;
        expect_pulse(8'h00, 0, "R5 falling ignored line0");
        pad_i = 8'h02;
        expect_pulse(8'h00, 0, "R5 rising ignored line1");
        pad_i = 8'h00;
        expect_pulse(8'h02, 3, "R4 falling line1");
        pad_i = 8'hF0;
        expect_pulse(8'hF0, 3, "R4 rising multi");
    endtask

    task automatic t_rewrite();
        apply_reset();
        bus_write(A_EDGE, 8'h04);        // line2 rising, pin low
        expect_pulse(8'h00, 0, "R6 setup");
        bus_write(A_EDGE, 8'h00);        // line2 to falling, pin low
        expect_pulse(8'h04, 1, "R6 edge 1->0 pin low");
        pad_i = 8'h08;                   // line3 rises under falling
        expect_pulse(8'h00, 0, "R6 setup pin high");
        bus_write(A_EDGE, 8'h08);
        expect_pulse(8'h08, 1, "R6 edge 0->1 pin high");
        bus_write(A_EDGE, 8'h00);
        expect_pulse(8'h00, 0, "R6 edge 1->0 pin high quiet");
    endtask

    task automatic t_regs();
        logic [7:0] d; logic v;
        apply_reset();
        bus_write(A_EDGE, 8'h5A);
        bus_write(A_DIR, 8'hC3);
        bus_write(5'h07, 8'hFF);
        bus_write(5'h00, 8'hFF);
        bus_read(A_EDGE, d, v); check(d == 8'h5A, "R7 edge readback", d, 8'h5A);
        bus_read(A_DIR,  d, v); check(d == 8'hC3, "R7 dir readback", d, 8'hC3);
        bus_read(A_DATA, d, v); check(d == 8'h00, "R9 data untouched", d, 8'h00);
        bus_read(5'h07,  d, v); check(d == 8'h00, "R7 unmapped read", d, 8'h00);
        check(pad_oe == 8'hC3, "R9 dir offset", pad_oe, 8'hC3);
    endtask

    task automatic t_handshake();
        logic [7:0] d; logic v;
        apply_reset();
        check(bus_rvalid == 1'b0, "R8 idle", {7'd0, bus_rvalid}, 8'h00);
        bus_read(A_DIR, d, v);
        check(v == 1'b1, "R8 rvalid", {7'd0, v}, 8'h01);
        @(negedge clk);
        check(bus_rvalid == 1'b0, "R8 one cycle", {7'd0, bus_rvalid}, 8'h00);
        bus_write(A_DIR, 8'h11);
        check(bus_rvalid == 1'b0, "R8 write no rvalid", {7'd0, bus_rvalid}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_direction();
        t_edges();
        t_rewrite();
        t_regs();
        t_handshake();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule